// File: doc/BRIEF.md
# Trace Timing Packet Generator

This block produces the timing packets that accompany an instruction-trace stream. It follows three related time bases, each arriving as a one-cycle enable strobe in a single clock domain. The first is a fixed-rate timestamp counter, which software or a trace controller samples into a full timestamp packet on request. The second is a crystal-clock count, which emits a short crystal-time packet at a power-of-two period that software selects. The third is a core-cycle count, which is reported on request as the number of core cycles since the last cycle packet.

Each packet leaves on one tagged output bus that uses a valid/ready handshake. Each source holds at most one packet pending. A four-state machine picks the next packet to send: ST_IDLE, ST_EMIT_STAMP, ST_EMIT_XTAL and ST_EMIT_CYC. It leaves ST_IDLE for the emit state of the highest-priority pending source. It leaves an emit state when the consumer accepts the packet (valid and ready both high). At that point it goes straight to the emit state of the next pending source, or back to ST_IDLE if nothing is pending. While the consumer withholds ready, it stays in the current emit state.

Top module: `tpg_timing_gen`

## Requirements
- R1: After reset pkt_valid is low and all three counters are zero. A first timestamp or cycle request with no strobes seen yields payload 0.
- R2: Each cycle with stamp_tick high adds one to the timestamp counter. A stamp_req produces a packet with pkt_kind 2'b00 whose pkt_data is the low 56 bits of the counter value at the clock edge where the request is sampled.
- R3: Each xtal_tick adds one to the crystal count. xtal_exp (4 bits, value N) sets the period to 2^N crystal edges. A packet with pkt_kind 2'b01 is raised whenever the count after an increment is a multiple of 2^N.
- R4: A cyc_req produces a packet with pkt_kind 2'b10 whose pkt_data is the number of core_tick cycles since the previous cycle capture. The count then restarts. A core_tick in the capture cycle itself counts toward the next packet.
- R5: The core-cycle count saturates at 2^CYC_W-1 and stays there until the next capture.
- R6: When several packets are pending, a timestamp packet goes first, then a crystal-time packet, then a cycle packet. A packet that loses arbitration stays pending.
- R7: While pkt_valid is high and pkt_ready is low, pkt_valid, pkt_kind and pkt_data stay unchanged.
- R8: A stamp_req or cyc_req that arrives while a packet of the same kind is pending is ignored. A newly due crystal-time packet replaces a pending one.
- R9: A crystal-time payload is bits [N+7:N] of the crystal count. The bits of pkt_data above bit 7 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stamp_tick | input | 1 | Timestamp counter advance strobe |
| stamp_req | input | 1 | Request a full timestamp packet |
| xtal_tick | input | 1 | Crystal clock edge strobe |
| xtal_exp | input | EXP_W | Crystal packet period exponent |
| core_tick | input | 1 | Core clock cycle strobe |
| cyc_req | input | 1 | Request a cycle packet |
| pkt_valid | output | 1 | Packet present |
| pkt_ready | input | 1 | Consumer accepts packet |
| pkt_kind | output | 2 | 00 timestamp, 01 crystal time, 10 cycles |
| pkt_data | output | 56 | Packet payload |

## Verification
The bench builds the block with CYC_W = 6, so saturation at 63 is reached within a few dozen strobes. The other parameters keep their defaults: a 24-bit crystal count and a 64-bit timestamp counter. Every crystal period exponent from 0 to 5 is swept tick by tick, and each tick is checked for a packet or for silence. A bulk run then pushes the crystal count past 2048, so that the 8-bit payload window at exponent 3 wraps. The bench also builds all the orderings it needs, namely three-way priority and backpressure with same-kind collisions, using only short stimulus sequences.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int unsigned PKT_PAY_W = 56;

    typedef enum logic [1:0] {
        PKT_STAMP = 2'b00,
        PKT_XTAL  = 2'b01,
        PKT_CYC   = 2'b10
    } pkt_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT_STAMP,
        ST_EMIT_XTAL,
        ST_EMIT_CYC
    } emit_state_e;
endpackage

// File: rtl/tpg_stamp_src.sv
module tpg_stamp_src #(
    parameter int unsigned STAMP_W = 64,
    parameter int unsigned PAY_W   = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             req_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic [PAY_W-1:0] pay_o
);
    logic [STAMP_W-1:0] cnt_q;
    logic               capture;

    // A request is accepted when the slot is empty or is emptied this cycle.
    assign capture = req_i && (!pend_o || take_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_o <= 1'b0;
            pay_o  <= '0;
        end else begin
            if (tick_i) cnt_q <= cnt_q + STAMP_W'(1);
            if (capture) begin
                pend_o <= 1'b1;
                pay_o  <= PAY_W'(cnt_q);
            end else if (take_i) begin
                pend_o <= 1'b0;
            end
        end
    end

    a_r2_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == $past(cnt_q) + STAMP_W'(1));

    a_r8_stamp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !take_i) |=> (pend_o && $stable(pay_o)));
endmodule

// File: rtl/tpg_xtal_src.sv
module tpg_xtal_src #(
    parameter int unsigned XTAL_W = 24,
    parameter int unsigned EXP_W  = 4,
    parameter int unsigned OUT_W  = 8,
    parameter int unsigned PAY_W  = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [EXP_W-1:0] exp_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic [PAY_W-1:0] pay_o
);
    localparam logic [XTAL_W-1:0] OUT_MASK = XTAL_W'((64'd1 << OUT_W) - 64'd1);

    logic [XTAL_W-1:0] cnt_q;
    logic [XTAL_W-1:0] cnt_nx;
    logic [XTAL_W-1:0] period_mask;
    logic              due;

    assign cnt_nx      = cnt_q + XTAL_W'(1);
    assign period_mask = (XTAL_W'(1) << exp_i) - XTAL_W'(1);
    assign due         = tick_i && ((cnt_nx & period_mask) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_o <= 1'b0;
            pay_o  <= '0;
        end else begin
            if (tick_i) cnt_q <= cnt_nx;
            // A newer due packet overwrites the one still waiting.
            if (due) begin
                pend_o <= 1'b1;
                pay_o  <= PAY_W'((cnt_nx >> exp_i) & OUT_MASK);
            end else if (take_i) begin
                pend_o <= 1'b0;
            end
        end
    end

    a_r3_xtal_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == $past(cnt_q) + XTAL_W'(1));

    a_r6_xtal_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !take_i) |=> pend_o);

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !tick_i) |=> !pend_o);
endmodule

// File: rtl/tpg_cyc_src.sv
module tpg_cyc_src #(
    parameter int unsigned CYC_W = 12,
    parameter int unsigned PAY_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             req_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic [PAY_W-1:0] pay_o
);
    localparam logic [CYC_W-1:0] CNT_MAX = '1;

    logic [CYC_W-1:0] cnt_q;
    logic             capture;

    assign capture = req_i && (!pend_o || take_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_o <= 1'b0;
            pay_o  <= '0;
        end else if (capture) begin
            pend_o <= 1'b1;
            pay_o  <= PAY_W'(cnt_q);
            // The strobe of the capture cycle opens the next interval.
            cnt_q  <= {{(CYC_W-1){1'b0}}, tick_i};
        end else begin
            if (take_i) pend_o <= 1'b0;
            if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CYC_W'(1);
        end
    end

    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !capture) |=> cnt_q == CNT_MAX);

    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> cnt_q <= CYC_W'(1));

    a_r8_cyc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !take_i) |=> (pend_o && $stable(pay_o)));
endmodule

// File: rtl/tpg_emit_fsm.sv
module tpg_emit_fsm
    import tpg_pkg::*;
#(
    parameter int unsigned PAY_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_s_i,
    input  logic             pend_x_i,
    input  logic             pend_c_i,
    input  logic [PAY_W-1:0] pay_s_i,
    input  logic [PAY_W-1:0] pay_x_i,
    input  logic [PAY_W-1:0] pay_c_i,
    input  logic             ready_i,
    output logic             take_s_o,
    output logic             take_x_o,
    output logic             take_c_o,
    output logic             valid_o,
    output logic [1:0]       kind_o,
    output logic [PAY_W-1:0] data_o
);
    emit_state_e state_q, state_nx;
    pkt_kind_e   kind_q;
    logic        slot_free;

    // Next-state selection with fixed priority: stamp, crystal, cycles.
    always_comb begin
        slot_free = (state_q == ST_IDLE) || ready_i;
        state_nx  = state_q;
        take_s_o  = 1'b0;
        take_x_o  = 1'b0;
        take_c_o  = 1'b0;
        if (slot_free) begin
            if (pend_s_i) begin
                state_nx = ST_EMIT_STAMP;
                take_s_o = 1'b1;
            end else if (pend_x_i) begin
                state_nx = ST_EMIT_XTAL;
                take_x_o = 1'b1;
            end else if (pend_c_i) begin
                state_nx = ST_EMIT_CYC;
                take_c_o = 1'b1;
            end else begin
                state_nx = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Output register: loaded only when the slot frees up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= PKT_STAMP;
            data_o <= '0;
        end else if (slot_free) begin
            unique case (state_nx)
                ST_EMIT_STAMP: begin kind_q <= PKT_STAMP; data_o <= pay_s_i; end
                ST_EMIT_XTAL:  begin kind_q <= PKT_XTAL;  data_o <= pay_x_i; end
                ST_EMIT_CYC:   begin kind_q <= PKT_CYC;   data_o <= pay_c_i; end
                ST_IDLE:       begin kind_q <= kind_q;    data_o <= data_o;  end
            endcase
        end
    end

    assign valid_o = (state_q != ST_IDLE);
    assign kind_o  = kind_q;

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(kind_o) && $stable(data_o)));

    a_r6_xtal_after_stamp: assert property (@(posedge clk) disable iff (!rst_n)
        take_x_o |-> !pend_s_i);

    a_r6_cyc_last: assert property (@(posedge clk) disable iff (!rst_n)
        take_c_o |-> (!pend_s_i && !pend_x_i));

    a_r6_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_s_o, take_x_o, take_c_o}));

    a_r6_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> kind_o != 2'b11);
endmodule

// File: rtl/tpg_timing_gen.sv
module tpg_timing_gen
    import tpg_pkg::*;
#(
    parameter int unsigned STAMP_W = 64,
    parameter int unsigned XTAL_W  = 24,
    parameter int unsigned CYC_W   = 12,
    parameter int unsigned EXP_W   = 4,
    parameter int unsigned XOUT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stamp_tick,
    input  logic                 stamp_req,
    input  logic                 xtal_tick,
    input  logic [EXP_W-1:0]     xtal_exp,
    input  logic                 core_tick,
    input  logic                 cyc_req,
    output logic                 pkt_valid,
    input  logic                 pkt_ready,
    output logic [1:0]           pkt_kind,
    output logic [PKT_PAY_W-1:0] pkt_data
);
    localparam int unsigned PAY_W = PKT_PAY_W;

    logic             pend_s, pend_x, pend_c;
    logic             take_s, take_x, take_c;
    logic [PAY_W-1:0] pay_s, pay_x, pay_c;

    tpg_stamp_src #(.STAMP_W(STAMP_W), .PAY_W(PAY_W)) u_stamp (
        .clk(clk), .rst_n(rst_n), .tick_i(stamp_tick), .req_i(stamp_req),
        .take_i(take_s), .pend_o(pend_s), .pay_o(pay_s)
    );

    tpg_xtal_src #(.XTAL_W(XTAL_W), .EXP_W(EXP_W), .OUT_W(XOUT_W), .PAY_W(PAY_W)) u_xtal (
        .clk(clk), .rst_n(rst_n), .tick_i(xtal_tick), .exp_i(xtal_exp),
        .take_i(take_x), .pend_o(pend_x), .pay_o(pay_x)
    );

    tpg_cyc_src #(.CYC_W(CYC_W), .PAY_W(PAY_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .tick_i(core_tick), .req_i(cyc_req),
        .take_i(take_c), .pend_o(pend_c), .pay_o(pay_c)
    );

    tpg_emit_fsm #(.PAY_W(PAY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pend_s_i(pend_s), .pend_x_i(pend_x), .pend_c_i(pend_c),
        .pay_s_i(pay_s), .pay_x_i(pay_x), .pay_c_i(pay_c),
        .ready_i(pkt_ready),
        .take_s_o(take_s), .take_x_o(take_x), .take_c_o(take_c),
        .valid_o(pkt_valid), .kind_o(pkt_kind), .data_o(pkt_data)
    );

    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> !pkt_valid);
endmodule

// File: tb/tb_tpg_timing_gen.sv
module tb_tpg_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CYC_W      = 6;
    localparam int CYC_MAX    = (1 << CYC_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stamp_tick, stamp_req, xtal_tick, core_tick, cyc_req, pkt_ready;
    logic [3:0]  xtal_exp;
    logic        pkt_valid;
    logic [1:0]  pkt_kind;
    logic [55:0] pkt_data;

    int          n_tests = 0;
    int          n_fail  = 0;
    longint      stamp_m = 0;
    longint      xtal_m  = 0;

    tpg_timing_gen #(.CYC_W(CYC_W)) dut (
        .clk(clk), .rst_n(rst_n), .stamp_tick(stamp_tick), .stamp_req(stamp_req),
        .xtal_tick(xtal_tick), .xtal_exp(xtal_exp), .core_tick(core_tick),
        .cyc_req(cyc_req), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_kind(pkt_kind), .pkt_data(pkt_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick_stamp(input int n);
        for (int i = 0; i < n; i++) begin
            stamp_tick = 1'b1; @(negedge clk); stamp_m++;
        end
        stamp_tick = 1'b0;
    endtask

    task automatic tick_core(input int n);
        for (int i = 0; i < n; i++) begin
            core_tick = 1'b1; @(negedge clk);
        end
        core_tick = 1'b0;
    endtask

    task automatic tick_xtal();
        xtal_tick = 1'b1; @(negedge clk); xtal_tick = 1'b0; xtal_m++;
    endtask

    task automatic pulse_stamp();
        stamp_req = 1'b1; @(negedge clk); stamp_req = 1'b0;
    endtask

    task automatic pulse_cyc();
        cyc_req = 1'b1; @(negedge clk); cyc_req = 1'b0;
    endtask

    task automatic expect_pkt(input logic [1:0] kind, input logic [55:0] data, input string tag);
        bit got = 0;
        logic [1:0]  k = 2'b11;
        logic [55:0] d = '0;
        for (int i = 0; i < 20 && !got; i++) begin
            if (pkt_valid) begin k = pkt_kind; d = pkt_data; got = 1; end
            @(negedge clk);
        end
        check(got && k == kind && d == data, tag, {6'd0, k, d}, {6'd0, kind, data});
    endtask

    task automatic expect_quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            if (pkt_valid) seen = 1;
            @(negedge clk);
        end
        check(!seen, tag, 64'(seen), 64'd0);
    endtask

    initial begin
        logic [1:0]  hk;
        logic [55:0] hd;
        bit          stable_ok;
        longint      a_val, b_val;
        rst_n = 1'b0; stamp_tick = 0; stamp_req = 0; xtal_tick = 0;
        core_tick = 0; cyc_req = 0; xtal_exp = 4'd0; pkt_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(!pkt_valid, "R1 valid low in reset", 64'(pkt_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pkt_valid, "R1 valid low after reset", 64'(pkt_valid), 64'd0);

        // R1: counters start at zero
        pulse_stamp(); expect_pkt(2'b00, 56'd0, "R1 stamp zero");
        pulse_cyc();   expect_pkt(2'b10, 56'd0, "R1 cycles zero");
        tick_xtal();   expect_pkt(2'b01, 56'd1, "R1 crystal first count");

        // R2: timestamp sweep
        for (int k = 0; k < 16; k++) begin
            tick_stamp((k * 5) % 13 + k);
            pulse_stamp();
            expect_pkt(2'b00, stamp_m[55:0], "R2 stamp value");
        end
        expect_quiet(6, "R2 no extra stamp packet");

        // R3 / R9: crystal period sweep, tick by tick
        for (int n = 0; n < 6; n++) begin
            xtal_exp = 4'(n);
            for (int j = 0; j < 3 * (1 << n); j++) begin
                tick_xtal();
                if ((xtal_m & ((64'd1 << n) - 1)) == 0)
                    expect_pkt(2'b01, 56'((xtal_m >> n) & 255), "R3 crystal due");
                else
                    expect_quiet(4, "R3 crystal not due");
            end
        end
        // push count past 2048 at the longest period, then check payload window wrap
        xtal_exp = 4'd15;
        xtal_tick = 1'b1;
        for (int i = 0; i < 2100; i++) begin @(negedge clk); xtal_m++; end
        xtal_tick = 1'b0;
        expect_quiet(4, "R3 long period silent");
        xtal_exp = 4'd3;
        for (int j = 0; j < 40; j++) begin
            tick_xtal();
            if ((xtal_m & 7) == 0)
                expect_pkt(2'b01, 56'((xtal_m >> 3) & 255), "R9 crystal payload window");
            else
                expect_quiet(3, "R3 crystal not due exp3");
        end

        // R4 / R5: cycle counts
        begin
            int lens [11] = '{0, 1, 2, 5, 9, 17, 33, 62, 63, 100, 200};
            foreach (lens[i]) begin
                tick_core(lens[i]);
                pulse_cyc();
                expect_pkt(2'b10, 56'((lens[i] > CYC_MAX) ? CYC_MAX : lens[i]),
                           (lens[i] > CYC_MAX) ? "R5 saturation" : "R4 cycle count");
            end
        end
        // R4: tick in the capture cycle goes to the next interval
        pkt_ready = 1'b0;
        tick_core(3);
        core_tick = 1'b1; cyc_req = 1'b1; @(negedge clk); cyc_req = 1'b0;
        tick_core(4);
        repeat (3) @(negedge clk);
        pulse_cyc();
        pkt_ready = 1'b1;
        expect_pkt(2'b10, 56'd3, "R4 capture before tick");
        expect_pkt(2'b10, 56'd5, "R4 capture tick counted next");

        // R6: simultaneous arrivals
        xtal_exp = 4'd0;
        stamp_req = 1'b1; xtal_tick = 1'b1; cyc_req = 1'b1;
        @(negedge clk);
        stamp_req = 1'b0; xtal_tick = 1'b0; cyc_req = 1'b0; xtal_m++;
        expect_pkt(2'b00, stamp_m[55:0], "R6 stamp first");
        expect_pkt(2'b01, 56'(xtal_m & 255), "R6 crystal second");
        expect_pkt(2'b10, 56'd0, "R6 cycles last");
        expect_quiet(4, "R6 nothing further");

        // R7 / R8: backpressure and same-kind collisions
        pkt_ready = 1'b0;
        tick_stamp(3);
        pulse_stamp(); a_val = stamp_m;
        repeat (3) @(negedge clk);
        hk = pkt_kind; hd = pkt_data;
        check(pkt_valid && hk == 2'b00 && hd == a_val[55:0], "R7 stalled packet",
              {6'd0, hk, hd}, {6'd0, 2'b00, a_val[55:0]});
        stable_ok = 1;
        tick_stamp(4);
        pulse_stamp(); b_val = stamp_m;
        tick_stamp(2);
        pulse_stamp();
        tick_xtal(); @(negedge clk); tick_xtal();
        for (int i = 0; i < 4; i++) begin
            if (!pkt_valid || pkt_kind != hk || pkt_data != hd) stable_ok = 0;
            @(negedge clk);
        end
        check(stable_ok, "R7 outputs stable under stall", 64'(stable_ok), 64'd1);
        pkt_ready = 1'b1;
        expect_pkt(2'b00, a_val[55:0], "R7 stalled packet delivered");
        expect_pkt(2'b00, b_val[55:0], "R8 pending stamp kept");
        expect_pkt(2'b01, 56'(xtal_m & 255), "R8 newer crystal replaces");
        expect_quiet(5, "R8 colliding stamp request ignored");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule